// File: doc/BRIEF.md
# Register-Programmed Serial Peripheral Master

This block is a serial peripheral interface (SPI) master. Software controls it through a small 32-bit register bus that has eight word slots, seven of them used. Software loads a transmit word, picks a slave, sets a clock divider and then writes a control word. The control word holds a bit count and a go bit. The block shifts that many bits out on MOSI in SPI mode 0: SCLK idles low, data changes on the falling edge and is sampled on the rising edge. At the same time it collects bits from MISO. When the last bit has been sent, it raises a completion flag.

Slave select lines are active low and one-hot. The core can drive them only while a transfer runs (automatic mode), or software can hold them directly so that several transfers share one select window (manual mode). A loopback switch feeds the outgoing serial data back into the receive path inside the block, so software can test the path without a slave attached.

Register offsets (word index on `bus_addr`): 0 control, 1 status, 2 transmit data, 3 receive data, 4 slave select, 5 loopback, 6 divider. A write to the status or receive slot changes nothing.

Top module: `spim_core`

## Requirements
- R1: After reset every `spi_cs_n` line is 1, SCLK and MOSI are 0, and the status and receive registers read 0.
- R2: A control write with bit 0 = 1 and a length L in bits [15:8], with 1 <= L <= 32, made while idle, starts a transfer. Status bit 0 reads 0 from the next cycle. SCLK makes exactly L low-to-high transitions and is low whenever no transfer runs. Status bit 0 reads 1 once the last bit period has ended.
- R3: MOSI sends the transmit register MSB-first, starting at bit L-1 and ending at bit 0. It changes only at the start of the transfer and on SCLK falling edges.
- R4: The receive register is cleared at start. On each SCLK rising edge it shifts left by one and takes the sampled bit into bit 0, so the first bit received ends at bit L-1.
- R5: Each SCLK half-period lasts max(D,1)+1 system clocks, where D is the divider register. The value is captured at start, so a divider write during a transfer does not affect that transfer.
- R6: With slave-select register bit 16 = 0 (automatic), line i of `spi_cs_n` is 0 only while a transfer runs and select bit i is 1. Otherwise it is 1.
- R7: With slave-select register bit 16 = 1 (manual), `spi_cs_n` equals the inverse of the select field at all times, whether a transfer runs or not.
- R8: With loopback register bit 0 = 1, the receive path samples the block's own MOSI and ignores the `spi_miso` pin. After L bits the receive register equals the low L bits of the transmit register.
- R9: A control write made while a transfer runs is ignored completely. The running transfer keeps its length, the stored length does not change and status bit 0 stays 0.
- R10: A start with L = 0 is ignored and leaves status bit 0 as it was. A start with L > 32 runs a 32-bit transfer.
- R11: The transmit, slave-select, loopback and divider registers read back as written. The control slot reads back the length in bits [15:8] and reads 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register word index |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NCS | One-hot slave selects, active low |

## Verification
The hardest case to reach from the ports is a register write that lands inside a running transfer. Examples are a second start with a different length, or a new divider value. Either write could corrupt the bit count or the clock timing without any visible change in the final status. The stimulus makes both writes part-way through a slow 16-bit transfer. A per-cycle reference model predicts SCLK and MOSI on every clock, and the bench counts SCLK edges, so a truncated or re-timed transfer shows up at once. The same per-cycle comparison covers the zero-length and over-length starts and the manual select window held across transfers.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam int BUS_W      = 32;
  localparam int ADDR_W     = 3;
  localparam int LEN_LSB    = 8;
  localparam int LEN_W      = 8;
  localparam int CSMODE_BIT = 16;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL = 3'd0,
    RA_STAT = 3'd1,
    RA_TXD  = 3'd2,
    RA_RXD  = 3'd3,
    RA_CSEL = 3'd4,
    RA_LOOP = 3'd5,
    RA_DIV  = 3'd6
  } reg_addr_e;

  // System clocks per SCLK half-period for a divider value.
  function automatic int unsigned half_clocks(input int unsigned div);
    return ((div == 0) ? 1 : div) + 1;
  endfunction

  // Bit count actually shifted for a requested length (0 means no transfer).
  function automatic int unsigned clamp_len(input int unsigned len, input int unsigned max_len);
    return (len > max_len) ? max_len : len;
  endfunction

endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             run,
  output logic             tick
);
  localparam int HALF_W = DIV_W + 1;

  logic [HALF_W-1:0] half_q;
  logic [HALF_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= HALF_W'(2);
    end else if (load) begin
      half_q <= HALF_W'(spim_pkg::half_clocks(32'(div_in)));
    end
  end

  assign tick = run && (cnt_q == half_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic [CNT_W-1:0]  start_len,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tick,
  input  logic              miso_in,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_data,
  output logic              sample_evt,
  output logic              finish_evt
);
  logic              busy_q;
  logic              hi_q;
  logic [DATA_W-1:0] txsh_q;
  logic [DATA_W-1:0] rxsh_q;
  logic [CNT_W-1:0]  left_q;
  logic              fall_evt;

  assign sample_evt = busy_q && tick && !hi_q;
  assign fall_evt   = busy_q && tick && hi_q;
  assign finish_evt = fall_evt && (left_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hi_q   <= 1'b0;
      txsh_q <= '0;
      rxsh_q <= '0;
      left_q <= '0;
    end else if (start_evt) begin
      busy_q <= 1'b1;
      hi_q   <= 1'b0;
      txsh_q <= tx_data << (DATA_W - int'(start_len));
      rxsh_q <= '0;
      left_q <= start_len;
    end else if (sample_evt) begin
      hi_q   <= 1'b1;
      rxsh_q <= {rxsh_q[DATA_W-2:0], miso_in};
    end else if (fall_evt) begin
      hi_q <= 1'b0;
      if (left_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
      end else begin
        txsh_q <= txsh_q << 1;
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign busy    = busy_q;
  assign sclk    = hi_q;
  assign mosi    = busy_q & txsh_q[DATA_W-1];
  assign rx_data = rxsh_q;

endmodule

// File: rtl/spim_csel.sv
module spim_csel #(
  parameter int NCS = 4
) (
  input  logic [NCS-1:0] sel,
  input  logic           manual,
  input  logic           busy,
  output logic [NCS-1:0] cs_n
);
  for (genvar i = 0; i < NCS; i++) begin : g_line
    assign cs_n[i] = ~(sel[i] & (manual | busy));
  end
endmodule

// File: rtl/spim_regs.sv
module spim_regs #(
  parameter int DATA_W = 32,
  parameter int NCS    = 4,
  parameter int DIV_W  = 16,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [spim_pkg::ADDR_W-1:0] addr,
  input  logic                        wr,
  input  logic [spim_pkg::BUS_W-1:0]  wdata,
  output logic [spim_pkg::BUS_W-1:0]  rdata,
  input  logic                        eng_busy,
  input  logic                        eng_finish,
  input  logic [DATA_W-1:0]           rx_data,
  output logic                        start_evt,
  output logic [CNT_W-1:0]            start_len,
  output logic [DATA_W-1:0]           tx_q,
  output logic [NCS-1:0]              cs_sel,
  output logic                        cs_man,
  output logic                        loop_en,
  output logic [DIV_W-1:0]            div_q,
  output logic                        done_q
);
  import spim_pkg::*;

  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] wlen;
  logic             ctrl_wr;

  assign wlen      = wdata[LEN_LSB +: LEN_W];
  assign ctrl_wr   = wr && (addr == RA_CTRL) && !eng_busy;
  assign start_evt = ctrl_wr && wdata[0] && (wlen != '0);
  assign start_len = CNT_W'(clamp_len(32'(wlen), DATA_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      tx_q    <= '0;
      cs_sel  <= '0;
      cs_man  <= 1'b0;
      loop_en <= 1'b0;
      div_q   <= '0;
    end else if (wr) begin
      case (reg_addr_e'(addr))
        RA_CTRL: if (!eng_busy) len_q <= wlen;
        RA_TXD:  tx_q <= wdata[DATA_W-1:0];
        RA_CSEL: begin
          cs_sel <= wdata[NCS-1:0];
          cs_man <= wdata[CSMODE_BIT];
        end
        RA_LOOP: loop_en <= wdata[0];
        RA_DIV:  div_q <= wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else if (start_evt) begin
      done_q <= 1'b0;
    end else if (eng_finish) begin
      done_q <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_addr_e'(addr))
      RA_CTRL: rdata[LEN_LSB +: LEN_W] = len_q;
      RA_STAT: rdata[0] = done_q;
      RA_TXD:  rdata = BUS_W'(tx_q);
      RA_RXD:  rdata = BUS_W'(rx_data);
      RA_CSEL: begin
        rdata[NCS-1:0]    = cs_sel;
        rdata[CSMODE_BIT] = cs_man;
      end
      RA_LOOP: rdata[0] = loop_en;
      RA_DIV:  rdata = BUS_W'(div_q);
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/spim_core.sv
module spim_core #(
  parameter int DATA_W = 32,
  parameter int NCS    = 4,
  parameter int DIV_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [spim_pkg::ADDR_W-1:0] bus_addr,
  input  logic                        bus_wr,
  input  logic [spim_pkg::BUS_W-1:0]  bus_wdata,
  output logic [spim_pkg::BUS_W-1:0]  bus_rdata,
  output logic                        spi_sclk,
  output logic                        spi_mosi,
  input  logic                        spi_miso,
  output logic [NCS-1:0]              spi_cs_n
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  // Named internal events, visible to the bound checker.
  logic              start_evt;
  logic              finish_evt;
  logic              sample_evt;
  logic              div_tick;
  logic              eng_busy;
  logic              done_q;
  logic              cs_man;
  logic [NCS-1:0]    cs_sel;
  logic              loop_en;
  logic              miso_int;
  logic [CNT_W-1:0]  start_len;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_data;
  logic [DIV_W-1:0]  div_q;

  spim_regs #(.DATA_W(DATA_W), .NCS(NCS), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (bus_addr),
    .wr         (bus_wr),
    .wdata      (bus_wdata),
    .rdata      (bus_rdata),
    .eng_busy   (eng_busy),
    .eng_finish (finish_evt),
    .rx_data    (rx_data),
    .start_evt  (start_evt),
    .start_len  (start_len),
    .tx_q       (tx_q),
    .cs_sel     (cs_sel),
    .cs_man     (cs_man),
    .loop_en    (loop_en),
    .div_q      (div_q),
    .done_q     (done_q)
  );

  spim_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start_evt),
    .div_in (div_q),
    .run    (eng_busy),
    .tick   (div_tick)
  );

  assign miso_int = loop_en ? spi_mosi : spi_miso;

  spim_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_evt  (start_evt),
    .start_len  (start_len),
    .tx_data    (tx_q),
    .tick       (div_tick),
    .miso_in    (miso_int),
    .busy       (eng_busy),
    .sclk       (spi_sclk),
    .mosi       (spi_mosi),
    .rx_data    (rx_data),
    .sample_evt (sample_evt),
    .finish_evt (finish_evt)
  );

  spim_csel #(.NCS(NCS)) u_csel (
    .sel    (cs_sel),
    .manual (cs_man),
    .busy   (eng_busy),
    .cs_n   (spi_cs_n)
  );

endmodule

// File: rtl/spim_core_chk.sv
module spim_core_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           spi_sclk,
  input logic           spi_mosi,
  input logic [NCS-1:0] spi_cs_n,
  input logic           done,
  input logic           start_evt,
  input logic           finish_evt,
  input logic           sample_evt,
  input logic           cs_man,
  input logic [NCS-1:0] cs_sel
);

  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sclk);

  p_done_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !done);

  p_finish_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> (done && !busy));

  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  p_sample_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |=> spi_sclk);

  p_half_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> !$past(spi_sclk, 2));

  p_auto_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_man && !busy) |-> (&spi_cs_n));

  p_manual_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_man && $past(cs_man) && $stable(cs_sel)) |-> $stable(spi_cs_n));

  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_evt);

endmodule

bind spim_core spim_core_chk #(.NCS(NCS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (eng_busy),
  .spi_sclk   (spi_sclk),
  .spi_mosi   (spi_mosi),
  .spi_cs_n   (spi_cs_n),
  .done       (done_q),
  .start_evt  (start_evt),
  .finish_evt (finish_evt),
  .sample_evt (sample_evt),
  .cs_man     (cs_man),
  .cs_sel     (cs_sel)
);

// File: tb/spim_core_bench.sv
`timescale 1ns/1ps
module spim_core_bench;
  localparam int NCS = 4;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_TXD = 3'd2, A_RXD = 3'd3,
                         A_CSEL = 3'd4, A_LOOP = 3'd5, A_DIV = 3'd6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [2:0]     bus_addr = '0;
  logic           bus_wr = 1'b0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic           spi_sclk, spi_mosi;
  logic           spi_miso = 1'b0;
  logic [NCS-1:0] spi_cs_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rises = 0;
  logic prev_sclk = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // Reference model state.
  bit          m_busy, m_done, m_man, m_loop;
  int          m_t, m_H, m_L;
  logic [31:0] m_txreg, m_txcap, m_rx;
  logic [7:0]  m_len;
  logic [3:0]  m_sel;
  logic [15:0] m_div;
  bit          b0, cur_mosi, cur_in;

  always #10 clk = ~clk;

  spim_core u_spim_core (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  function automatic bit exp_sclk();
    return m_busy && ((m_t % (2 * m_H)) >= m_H);
  endfunction

  function automatic bit exp_mosi();
    int k;
    if (!m_busy) return 1'b0;
    k = m_t / (2 * m_H);
    return m_txcap[m_L - 1 - k];
  endfunction

  function automatic logic [3:0] exp_cs();
    if (m_man || m_busy) return ~m_sel;
    return 4'hF;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference, advanced on every rising edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_man = 0; m_loop = 0; m_t = 0; m_H = 2; m_L = 1;
      m_txreg = '0; m_txcap = '0; m_rx = '0; m_len = '0; m_sel = '0; m_div = '0;
    end else begin
      b0 = m_busy;
      cur_mosi = exp_mosi();
      cur_in = m_loop ? cur_mosi : spi_miso;
      if (m_busy) begin
        if ((m_t % (2 * m_H)) == m_H - 1) m_rx = {m_rx[30:0], cur_in};
        m_t++;
        if (m_t == 2 * m_H * m_L) begin
          m_busy = 0;
          m_done = 1;
        end
      end
      if (bus_wr) begin
        case (bus_addr)
          A_CTRL: if (!b0) begin
            m_len = bus_wdata[15:8];
            if (bus_wdata[0] && m_len != 0) begin
              m_L = (m_len > 32) ? 32 : int'(m_len);
              m_H = ((m_div == 0) ? 1 : int'(m_div)) + 1;
              m_txcap = m_txreg;
              m_t = 0; m_busy = 1; m_done = 0; m_rx = '0;
            end
          end
          A_TXD:  m_txreg = bus_wdata;
          A_CSEL: begin m_sel = bus_wdata[3:0]; m_man = bus_wdata[16]; end
          A_LOOP: m_loop = bus_wdata[0];
          A_DIV:  m_div = bus_wdata[15:0];
          default: ;
        endcase
      end
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (spi_sclk && !prev_sclk) rises++;
      prev_sclk = spi_sclk;
      check(spi_sclk === exp_sclk(), "R2/R5 sclk", 32'(spi_sclk), 32'(exp_sclk()));
      check(spi_mosi === exp_mosi(), "R3 mosi", 32'(spi_mosi), 32'(exp_mosi()));
      check(spi_cs_n === exp_cs(), "R6/R7 cs_n", 32'(spi_cs_n), 32'(exp_cs()));
    end
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    spi_miso <= lfsr[0];
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #2;
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && m_busy; i++) @(negedge clk);
    idle(2);
  endtask

  // Run one transfer and check status, receive data and edge count.
  task automatic xfer(input logic [31:0] tx, input int len, input int exp_edges, input string req);
    logic [31:0] v;
    int base;
    wr(A_TXD, tx);
    base = rises;
    wr(A_CTRL, (32'(len) << 8) | 32'h1);
    rd(A_STAT, v);
    check(v[0] === 1'b0, "R2 done low after start", v, 0);
    wait_done();
    rd(A_STAT, v);
    check(v[0] === 1'b1, "R2 done high at end", v, 1);
    rd(A_RXD, v);
    check(v === m_rx, "R4 receive word", v, m_rx);
    check(rises - base == exp_edges, req, rises - base, exp_edges);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    int base;
    idle(5);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    rd(A_STAT, v); check(v === 0, "R1 status", v, 0);
    rd(A_RXD, v);  check(v === 0, "R1 receive", v, 0);
    check(spi_cs_n === 4'hF, "R1 cs_n", 32'(spi_cs_n), 32'hF);
    check(spi_sclk === 1'b0 && spi_mosi === 1'b0, "R1 sclk/mosi", 32'({spi_sclk, spi_mosi}), 0);

    // R2 R3 R4: 8-bit transfer, fastest clock, auto select on line 0
    wr(A_DIV, 0);
    wr(A_CSEL, 32'h1);
    xfer(32'h0000_00A5, 8, 8, "R2 edge count len 8");

    // R5: divider 3, full word on line 2
    wr(A_DIV, 3);
    wr(A_CSEL, 32'h4);
    xfer(32'hDEAD_BEEF, 32, 32, "R5 edge count len 32");

    // R3: partial length starts from bit L-1
    wr(A_DIV, 1);
    xfer(32'hFFFF_2B5F, 13, 13, "R3 edge count len 13");

    // R8: loopback returns the transmitted low bits
    wr(A_LOOP, 32'h1);
    xfer(32'h1234_C3A5, 16, 16, "R8 edge count");
    rd(A_RXD, v); check(v === 32'h0000_C3A5, "R8 loopback data", v, 32'h0000_C3A5);
    wr(A_LOOP, 32'h0);

    // R7: manual select held before, during and after a transfer
    wr(A_CSEL, 32'h0001_0002);
    idle(2);
    check(spi_cs_n === 4'b1101, "R7 manual idle", 32'(spi_cs_n), 32'hD);
    xfer(32'h0000_0015, 5, 5, "R7 edge count");
    check(spi_cs_n === 4'b1101, "R7 manual after", 32'(spi_cs_n), 32'hD);
    // R6: back to automatic releases the line when idle
    wr(A_CSEL, 32'h0000_0002);
    idle(1);
    check(spi_cs_n === 4'hF, "R6 auto idle", 32'(spi_cs_n), 32'hF);

    // R9 and R5: writes during a slow transfer
    wr(A_DIV, 2);
    wr(A_TXD, 32'h0000_F0F0);
    base = rises;
    wr(A_CTRL, (32'd16 << 8) | 32'h1);
    idle(10);
    wr(A_CTRL, (32'd3 << 8) | 32'h1);
    wr(A_DIV, 7);
    rd(A_STAT, v); check(v[0] === 1'b0, "R9 done stays low", v, 0);
    wait_done();
    check(rises - base == 16, "R9 length kept", rises - base, 16);
    rd(A_CTRL, v); check(v === 32'h0000_1000, "R9 stored length", v, 32'h0000_1000);
    rd(A_RXD, v); check(v === m_rx, "R4 receive after restart attempt", v, m_rx);

    // R10: zero length ignored, done unchanged
    base = rises;
    wr(A_CTRL, 32'h1);
    idle(6);
    rd(A_STAT, v); check(v[0] === 1'b1, "R10 zero length keeps done", v, 1);
    check(rises - base == 0, "R10 zero length no edges", rises - base, 0);
    // R10: over-length clamps to 32
    wr(A_DIV, 0);
    xfer(32'h8000_0001, 40, 32, "R10 clamp to 32 edges");

    // R11 readback
    wr(A_CSEL, 32'h0001_0008);
    wr(A_LOOP, 32'h1);
    wr(A_DIV, 32'h0000_0123);
    rd(A_TXD, v);  check(v === 32'h8000_0001, "R11 transmit", v, 32'h8000_0001);
    rd(A_CSEL, v); check(v === 32'h0001_0008, "R11 select", v, 32'h0001_0008);
    rd(A_LOOP, v); check(v === 32'h1, "R11 loopback", v, 1);
    rd(A_DIV, v);  check(v === 32'h123, "R11 divider", v, 32'h123);
    rd(A_CTRL, v); check(v === 32'h0000_2800, "R11 control", v, 32'h0000_2800);

    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule